// File: doc/BRIEF.md
# Cascadable Timer with Selectable Trigger Output

This block is a free-running up-counter with a programmable wrap value, two compare channels and one trigger line. A downstream timer can use that line to start, gate or reset itself. A 3-bit source code picks which internal event of this timer drives the trigger line. The choices are a software counter restart, the run level, the update event, a compare-match pulse, or one of the two compare reference waveforms. Each compare channel also raises a one-cycle DMA request strobe. A shared select bit decides whether that strobe follows the channel's own match or the update event.

Software writes a small control word (run bit, trigger source, DMA timing select) and an event word (update request) through a single-cycle write port. The wrap value and the compare values arrive as plain inputs. Compare-match flags are visible as outputs and are cleared by a per-channel clear input.

The counter is a two-state machine. CTR_IDLE means the counter holds. CTR_RUN means it counts. Writing the control word with the run bit at 1 takes CTR_IDLE to CTR_RUN. Writing it with the run bit at 0 takes CTR_RUN to CTR_IDLE. Any other cycle keeps the current state.

Top module: `timer_cascade_trig`

## Requirements
- R1: After reset the trigger line, both DMA strobes, both compare flags and the counter value are all 0. The counter is in CTR_IDLE and the trigger source code is 000.
- R2: A write with cfg_addr=0 loads the control word: bit 0 is the run bit, bits 3:1 are the trigger source, bit 4 is the DMA select. In CTR_RUN the counter steps by one per clock, starting on the second clock after the write. When it equals reload_val it returns to 0 on the next clock, and that equality cycle is an update event. In CTR_IDLE the counter holds its value.
- R3: A write with cfg_addr=1 and cfg_wdata[0]=1 is an update request. It forces the counter to 0 on the next clock and is itself an update event.
- R4: Source 000: the trigger line is high for exactly the one clock that follows an update request, and low otherwise.
- R5: Source 001: the trigger line equals the run state (1 in CTR_RUN) delayed by one clock.
- R6: Source 010: the trigger line is high for one clock following each update event.
- R7: Source 011: the trigger line is high for one clock following any cycle where a channel matches, that is, the counter is running and equals that channel's compare value.
- R8: Sources 100 and 101: the trigger line follows, one clock late, the reference of channel 1 or channel 2 respectively. A reference is high while the counter is below the channel compare value.
- R9: Sources 110 and 111: the trigger line stays low.
- R10: A channel match sets that channel's flag on the next clock. A high flag_clr bit clears the flag on the next clock, and a simultaneous match wins over the clear.
- R11: With DMA select 0, a channel's DMA strobe is high for the one clock after that channel's match.
- R12: With DMA select 1, both DMA strobes are high for the one clock after each update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control or event word |
| cfg_addr | input | 1 | 0 selects the control word, 1 selects the event word |
| cfg_wdata | input | 5 | Write data (layout in R2 and R3) |
| reload_val | input | 16 | Value at which the counter wraps to 0 |
| cmp_val | input | 2x16 | Compare values, index 0 is channel 1 |
| flag_clr | input | 2 | Per-channel compare flag clear |
| cmp_flag | output | 2 | Per-channel compare match flags |
| dma_req | output | 2 | Per-channel one-cycle DMA request strobes |
| trig_out | output | 1 | Trigger line to cascaded timers |
| cnt_out | output | 16 | Current counter value |

## Verification
The hardest case to reach is a match arriving in the same clock as a held flag clear, where the set must win. The stimulus holds the clear bit of channel 1 high from before the counter starts. The flag is then sampled on the exact cycle after the computed match and again one clock later. A second awkward case is the single-cycle pulse for source 000. It appears only after an update request written while the counter runs mid-period, so the bench issues that write at a known cycle far from any wrap or match. All expected trigger, DMA and counter values are placed in a queue as cycle-stamped items and compared as the cycles pass.

// File: rtl/ctc_pkg.sv
`timescale 1ns/1ps
package ctc_pkg;
    typedef enum logic [2:0] {
        TRG_RST  = 3'd0,
        TRG_EN   = 3'd1,
        TRG_UPD  = 3'd2,
        TRG_CMPP = 3'd3,
        TRG_REF1 = 3'd4,
        TRG_REF2 = 3'd5,
        TRG_RSV6 = 3'd6,
        TRG_RSV7 = 3'd7
    } trg_src_e;

    typedef enum logic {
        CTR_IDLE = 1'b0,
        CTR_RUN  = 1'b1
    } ctr_state_e;

    localparam int EN_BIT   = 0;
    localparam int MODE_LSB = 1;
    localparam int MODE_MSB = 3;
    localparam int DSEL_BIT = 4;
    localparam int UG_BIT   = 0;
    localparam logic CFG_CTRL  = 1'b0;
    localparam logic CFG_EVGEN = 1'b1;
endpackage

// File: rtl/ctc_counter.sv
`timescale 1ns/1ps
module ctc_counter
    import ctc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_wr,
    input  logic             run_val,
    input  logic             ug,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             wrap
);
    ctr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state logic: only a control write moves the machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTR_IDLE: if (run_wr && run_val)  state_d = CTR_RUN;
            CTR_RUN:  if (run_wr && !run_val) state_d = CTR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTR_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the machine
    always_comb begin
        run  = 1'b0;
        wrap = 1'b0;
        unique case (state_q)
            CTR_IDLE: run = 1'b0;
            CTR_RUN: begin
                run  = 1'b1;
                wrap = (cnt_q == reload);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (ug)   cnt_q <= '0;
        else if (run)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ctc_channel.sv
`timescale 1ns/1ps
module ctc_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run,
    input  logic [CNT_W-1:0] cmp,
    input  logic             clr,
    input  logic             dsel,
    input  logic             upd,
    output logic             evt,
    output logic             oref,
    output logic             flag,
    output logic             dreq
);
    assign evt  = run && (cnt == cmp);
    assign oref = (cnt < cmp);

    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (evt)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dreq <= 1'b0;
        else        dreq <= dsel ? upd : evt;
    end
endmodule

// File: rtl/ctc_trig_sel.sv
`timescale 1ns/1ps
module ctc_trig_sel
    import ctc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  trg_src_e       mode,
    input  logic           ug,
    input  logic           run,
    input  logic           upd,
    input  logic [NCH-1:0] evt,
    input  logic [NCH-1:0] oref,
    output logic           trig
);
    logic trig_d;

    always_comb begin
        trig_d = 1'b0;
        unique case (mode)
            TRG_RST:  trig_d = ug;
            TRG_EN:   trig_d = run;
            TRG_UPD:  trig_d = upd;
            TRG_CMPP: trig_d = |evt;
            TRG_REF1: trig_d = oref[0];
            TRG_REF2: trig_d = oref[1];
            TRG_RSV6: trig_d = 1'b0;
            TRG_RSV7: trig_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= trig_d;
    end
endmodule

// File: rtl/timer_cascade_trig.sv
`timescale 1ns/1ps
module timer_cascade_trig
    import ctc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2,
    parameter int CFG_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_addr,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic [CNT_W-1:0]          reload_val,
    input  logic [NCH-1:0][CNT_W-1:0] cmp_val,
    input  logic [NCH-1:0]            flag_clr,
    output logic [NCH-1:0]            cmp_flag,
    output logic [NCH-1:0]            dma_req,
    output logic                      trig_out,
    output logic [CNT_W-1:0]          cnt_out
);
    logic             ctl_wr, ug;
    trg_src_e         mode_q;
    logic             sel_q;
    logic [CNT_W-1:0] cnt;
    logic             run, wrap, upd_evt;
    logic [NCH-1:0]   cmp_evt, cmp_ref;

    assign ctl_wr = cfg_we && (cfg_addr == CFG_CTRL);
    assign ug     = cfg_we && (cfg_addr == CFG_EVGEN) && cfg_wdata[UG_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TRG_RST;
            sel_q  <= 1'b0;
        end else if (ctl_wr) begin
            mode_q <= trg_src_e'(cfg_wdata[MODE_MSB:MODE_LSB]);
            sel_q  <= cfg_wdata[DSEL_BIT];
        end
    end

    ctc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_wr  (ctl_wr),
        .run_val (cfg_wdata[EN_BIT]),
        .ug      (ug),
        .reload  (reload_val),
        .cnt     (cnt),
        .run     (run),
        .wrap    (wrap)
    );

    assign upd_evt = wrap || ug;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ctc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt),
            .run   (run),
            .cmp   (cmp_val[i]),
            .clr   (flag_clr[i]),
            .dsel  (sel_q),
            .upd   (upd_evt),
            .evt   (cmp_evt[i]),
            .oref  (cmp_ref[i]),
            .flag  (cmp_flag[i]),
            .dreq  (dma_req[i])
        );
    end

    ctc_trig_sel #(.NCH(NCH)) u_trg (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_q),
        .ug    (ug),
        .run   (run),
        .upd   (upd_evt),
        .evt   (cmp_evt),
        .oref  (cmp_ref),
        .trig  (trig_out)
    );

    assign cnt_out = cnt;
endmodule

// File: rtl/ctc_checker.sv
`timescale 1ns/1ps
module ctc_checker #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode,
    input logic             sel,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             ug,
    input logic             upd_evt,
    input logic [NCH-1:0]   cmp_evt,
    input logic             trig_out,
    input logic [NCH-1:0]   dma_req,
    input logic [NCH-1:0]   cmp_flag
);
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == reload && !ug) |=> (cnt == '0)); // R2
    AST_UG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt == '0)); // R3
    AST_RST_SRC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd0 && trig_out) |-> $past(ug)); // R4
    AST_EN_SRC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd1) |-> (trig_out == $past(run))); // R5
    AST_RSV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) >= 3'd6) |-> !trig_out); // R9
    AST_DMA_ON_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> (dma_req == $past(cmp_evt))); // R11
    AST_DMA_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel) |-> (dma_req == {NCH{$past(upd_evt)}})); // R12
    for (genvar i = 0; i < NCH; i++) begin : g_f
        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_evt[i] |=> cmp_flag[i]); // R10
    end
endmodule

bind timer_cascade_trig ctc_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .sel      (sel_q),
    .run      (run),
    .cnt      (cnt),
    .reload   (reload_val),
    .ug       (ug),
    .upd_evt  (upd_evt),
    .cmp_evt  (cmp_evt),
    .trig_out (trig_out),
    .dma_req  (dma_req),
    .cmp_flag (cmp_flag)
);

// File: tb/timer_cascade_trig_tb_top.sv
`timescale 1ns/1ps
module timer_cascade_trig_tb_top;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_addr = 1'b0;
    logic [4:0]       cfg_wdata = '0;
    logic [15:0]      reload_val = '0;
    logic [1:0][15:0] cmp_val = '0;
    logic [1:0]       flag_clr = '0;
    logic [1:0]       cmp_flag, dma_req;
    logic             trig_out;
    logic [15:0]      cnt_out;

    always #2.5 clk = ~clk;

    timer_cascade_trig dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .reload_val(reload_val), .cmp_val(cmp_val),
        .flag_clr(flag_clr), .cmp_flag(cmp_flag), .dma_req(dma_req),
        .trig_out(trig_out), .cnt_out(cnt_out)
    );

    typedef struct {
        int         cyc;
        logic       trig;
        logic [1:0] dma;
        int         cnt;
        string      req;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    int m_c, m_r, m_c1, m_c2, m_mode, m_sel;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, bit ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // monitor: pops due items and compares
    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                chk({e.req, " item cycle"}, e.cyc == cyc, cyc, e.cyc);
                chk({e.req, " trig"}, trig_out === e.trig, int'(trig_out), int'(e.trig));
                chk({e.req, " dma"}, dma_req === e.dma, int'(dma_req), int'(e.dma));
                chk({e.req, " cnt"}, int'(cnt_out) == e.cnt, int'(cnt_out), e.cnt);
            end
        end
    end

    function automatic int cntat(int j);
        return (j >= m_c + 1) ? (j - m_c - 1) % (m_r + 1) : 0;
    endfunction
    function automatic bit runat(int j);
        return j >= m_c + 1;
    endfunction
    function automatic bit wrapat(int j);
        return runat(j) && cntat(j) == m_r;
    endfunction
    function automatic bit cmpat(int j, int c);
        return runat(j) && cntat(j) == c;
    endfunction
    function automatic logic e_trig(int k);
        int j = k - 1;
        case (m_mode)
            1: return runat(j);
            2: return wrapat(j);
            3: return cmpat(j, m_c1) || cmpat(j, m_c2);
            4: return cntat(j) < m_c1;
            5: return cntat(j) < m_c2;
            default: return 1'b0;
        endcase
    endfunction
    function automatic logic [1:0] e_dma(int k);
        int j = k - 1;
        if (m_sel != 0) return {2{wrapat(j)}};
        return {cmpat(j, m_c2), cmpat(j, m_c1)};
    endfunction

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; flag_clr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic a, logic [4:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: starts a run and pushes cycle-stamped expected items
    task automatic scn_start(int mode, int sel, int r, int c1, int c2, int n,
                             logic [1:0] clr, string req);
        do_reset();
        flag_clr = clr;
        reload_val = 16'(r); cmp_val[0] = 16'(c1); cmp_val[1] = 16'(c2);
        m_mode = mode; m_sel = sel; m_r = r; m_c1 = c1; m_c2 = c2;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 1'b0;
        cfg_wdata = {sel[0], mode[2:0], 1'b1};
        m_c = cyc;
        for (int k = m_c + 2; k <= m_c + 1 + n; k++) begin
            exp_t e;
            e.cyc = k; e.trig = e_trig(k); e.dma = e_dma(k); e.cnt = cntat(k); e.req = req;
            q.push_back(e);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic scn(int mode, int sel, int r, int c1, int c2, int n, string req);
        scn_start(mode, sel, r, c1, c2, n, 2'b00, req);
        wait_cyc(m_c + 2 + n);
    endtask

    initial begin
        int u, a, b;
        do_reset();
        @(negedge clk);
        chk("R1 trig", trig_out === 1'b0, int'(trig_out), 0);
        chk("R1 dma", dma_req === 2'b00, int'(dma_req), 0);
        chk("R1 flag", cmp_flag === 2'b00, int'(cmp_flag), 0);
        chk("R1 cnt", cnt_out === 16'd0, int'(cnt_out), 0);

        scn(1, 0, 9, 3, 7, 25, "R5 R11 R2");
        scn(2, 1, 5, 2, 4, 20, "R6 R12 R2");
        scn(3, 0, 7, 1, 5, 20, "R7 R11");
        chk("R10 flags set", cmp_flag === 2'b11, int'(cmp_flag), 3);
        wr(1'b0, {1'b0, 3'd3, 1'b0});
        repeat (2) @(negedge clk);
        flag_clr = 2'b11;
        @(negedge clk);
        flag_clr = 2'b00;
        chk("R10 flags cleared", cmp_flag === 2'b00, int'(cmp_flag), 0);

        scn(4, 0, 9, 4, 6, 22, "R8 ch1");
        scn(5, 0, 9, 4, 6, 22, "R8 ch2");
        scn(6, 0, 9, 4, 6, 14, "R9 code6");
        scn(7, 1, 9, 0, 6, 14, "R9 code7");

        // source 000 with an update request mid-period
        scn(0, 1, 20, 30, 30, 6, "R4 idle");
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 5'd1;
        u = cyc;
        begin
            exp_t e1, e2;
            e1.cyc = u + 1; e1.trig = 1'b1; e1.dma = 2'b11; e1.cnt = 0; e1.req = "R3 R4 R12 pulse";
            e2.cyc = u + 2; e2.trig = 1'b0; e2.dma = 2'b00; e2.cnt = 1; e2.req = "R3 R4 after";
            q.push_back(e1); q.push_back(e2);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        wait_cyc(u + 3);
        wr(1'b0, {1'b1, 3'd0, 1'b0});
        @(negedge clk);
        a = int'(cnt_out);
        repeat (4) @(negedge clk);
        b = int'(cnt_out);
        chk("R2 hold when idle", a == b, b, a);

        // match in the same cycle as a held clear: set wins
        scn_start(3, 0, 15, 4, 20, 8, 2'b01, "R7 R10");
        wait_cyc(m_c + 6);
        chk("R10 set wins", cmp_flag[0] === 1'b1, int'(cmp_flag[0]), 1);
        wait_cyc(m_c + 7);
        chk("R10 clear after", cmp_flag[0] === 1'b0, int'(cmp_flag[0]), 0);
        wait_cyc(m_c + 10);

        chk("queue drained", q.size() == 0, q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule